// File: doc/BRIEF.md
# Transmit Cell Framer with Timing-Marker Insertion

This block forms the outgoing serial stream of a 25.6 Mbps ATM physical layer. An ATM-layer source hands it 53-byte cells one byte at a time over a valid/ready handshake. Before each cell the framer sends a two-symbol command byte: an escape symbol and then a symbol that says whether the scrambler restarts. Cell bytes pass through a nibble scrambler. Every byte is then sent as two 5-bit symbols, and the resulting bit stream leaves NRZI coded on a single line bit, one bit per clock.

An 8 kHz sync pulse causes a timing-marker command byte to be sent at the next byte boundary. It takes precedence over data bytes and start-of-cell commands. A cell that is in progress is paused for the length of that one byte and then continues with no byte lost. When no cell is pending, idle data symbols keep valid coding on the line.

Top module: `cellframe_tx`

## Requirements
- R1: While `rst_n` is low and straight after it rises, `line_o` is 0 and `cell_ready_o` is 0. The first byte slots on the line decode as idle bytes.
- R2: A cell whose first byte arrives with `cell_sof_i` and `cell_scr_rst_i` both high is preceded by the command escape,escape. The scrambler is reloaded with the seed (default 10'h3FF) before the cell's first data byte.
- R3: A cell whose first byte arrives with `cell_sof_i` high and `cell_scr_rst_i` low is preceded by escape followed by the code for nibble 4. The scrambler continues from its current state.
- R4: A `sync_i` pulse causes the marker command, escape followed by the code for nibble 8, to be sent in the next byte slot. The marker wins over a pending start-of-cell command and over cell data.
- R5: A marker requested during a cell takes one byte slot between two cell bytes. `cell_ready_o` stays low for that slot, and all 53 bytes still arrive in order.
- R6: A `sync_i` pulse seen while a marker is being sent is held. A second marker follows in the very next byte slot.
- R7: Each cell byte is XORed with an 8-bit key taken from a 10-bit LFSR that steps 8 times per cell byte. On each step fb = XOR of (state AND taps), with default taps 10'h240. The new state is {state[8:0], fb}, and the fb values fill the key MSB first. Command symbols are never scrambled.
- R8: Bytes are sent high nibble first, and each symbol is sent MSB first. The nibble codes 0..F are 11110, 01001, 10100, 10101, 01010, 01011, 01110, 01111, 10010, 10011, 10110, 10111, 11010, 11011, 11100, 11101. Escape is 11000. No other code appears.
- R9: The line is NRZI coded: `line_o` toggles for a 1 bit and holds for a 0 bit.
- R10: When no cell is pending, the framer sends the unscrambled byte 0x00. The scrambler state does not change during idle or marker slots.
- R11: A byte slot lasts 10 clocks. Within a cell, `cell_ready_o` is high for only one clock per slot, so bytes are taken 10 clocks apart when no marker intervenes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cell_data_i | input | 8 | Cell byte from the ATM layer |
| cell_valid_i | input | 1 | Cell byte is valid |
| cell_sof_i | input | 1 | Byte is the first of a cell |
| cell_scr_rst_i | input | 1 | With the first byte: restart the scrambler |
| cell_ready_o | output | 1 | Byte is taken at this clock edge |
| sync_i | input | 1 | 8 kHz timing sync pulse |
| line_o | output | 1 | NRZI serial line bit |

## Verification
A byte is taken on the edge that closes a slot. Its first bit reaches `line_o` one edge later, and its last bit ten edges later. A sync pulse therefore shows up on the line as a marker within 11 to 20 clocks. The bench never samples at fixed cycle offsets. It recovers the stream at falling edges: it decodes NRZI from the first edge after reset, and slot alignment follows from that edge. Only after the pipeline has drained does it compare the recovered commands, bytes and marker positions with the values it predicted. Handshake spacing is measured between the falling edges at which `cell_ready_o` is seen high.

// File: rtl/cellframe_pkg.sv
package cellframe_pkg;
  localparam int SYM_W  = 5;
  localparam int NIB_W  = 4;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 2 * SYM_W;

  localparam logic [SYM_W-1:0] SYM_ESC = 5'b11000;

  typedef enum logic [2:0] {
    SLOT_IDLE,
    SLOT_DATA,
    SLOT_CMD_RST,
    SLOT_CMD_KEEP,
    SLOT_MARK
  } slot_kind_t;

  function automatic logic [SYM_W-1:0] enc_nib(input logic [NIB_W-1:0] n);
    logic [SYM_W-1:0] s;
    case (n)
      4'h0: s = 5'b11110;
      4'h1: s = 5'b01001;
      4'h2: s = 5'b10100;
      4'h3: s = 5'b10101;
      4'h4: s = 5'b01010;
      4'h5: s = 5'b01011;
      4'h6: s = 5'b01110;
      4'h7: s = 5'b01111;
      4'h8: s = 5'b10010;
      4'h9: s = 5'b10011;
      4'hA: s = 5'b10110;
      4'hB: s = 5'b10111;
      4'hC: s = 5'b11010;
      4'hD: s = 5'b11011;
      4'hE: s = 5'b11100;
      default: s = 5'b11101;
    endcase
    return s;
  endfunction

  localparam logic [WORD_W-1:0] IDLE_WORD = {5'b11110, 5'b11110};
endpackage

// File: rtl/cellframe_scrambler.sv
module cellframe_scrambler #(
  parameter int                LFSR_W = 10,
  parameter logic [LFSR_W-1:0] TAPS   = 10'h240,
  parameter logic [LFSR_W-1:0] SEED   = 10'h3FF,
  parameter int                KEY_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             adv_i,
  output logic [KEY_W-1:0] key_o
);
  logic [LFSR_W-1:0] state_q, state_d, state_adv;

  always_comb begin
    logic [LFSR_W-1:0] st;
    logic              fb;
    st = state_q;
    key_o = '0;
    for (int k = 0; k < KEY_W; k++) begin
      fb = ^(st & TAPS);
      key_o[KEY_W-1-k] = fb;
      st = {st[LFSR_W-2:0], fb};
    end
    state_adv = st;
  end

  always_comb begin
    state_d = state_q;
    if (load_i)     state_d = SEED;
    else if (adv_i) state_d = state_adv;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SEED;
    else        state_q <= state_d;
  end

  // R2: a restart request leaves the generator at its seed
  p_seed_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (state_q == SEED));
  // R10: no cell byte, no movement
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !adv_i) |=> $stable(state_q));
  // R7: the generator never locks up at zero
  p_nonzero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    state_q != '0);
endmodule

// File: rtl/cellframe_sched.sv
module cellframe_sched
  import cellframe_pkg::*;
#(
  parameter int CELL_BYTES = 53
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slot_end_i,
  input  logic [BYTE_W-1:0] cell_data_i,
  input  logic              cell_valid_i,
  input  logic              cell_sof_i,
  input  logic              cell_scr_rst_i,
  input  logic              sync_i,
  input  logic [BYTE_W-1:0] key_i,
  output logic              cell_ready_o,
  output logic              scr_load_o,
  output logic              scr_adv_o,
  output logic [WORD_W-1:0] word_o
);
  localparam int REM_W = $clog2(CELL_BYTES + 1);

  logic [REM_W-1:0] rem_q, rem_d;
  logic             pend_q, pend_d;
  slot_kind_t       kind;
  logic [BYTE_W-1:0] scr_byte;

  always_comb begin
    kind         = SLOT_IDLE;
    cell_ready_o = 1'b0;
    scr_load_o   = 1'b0;
    scr_adv_o    = 1'b0;
    rem_d        = rem_q;
    if (slot_end_i) begin
      if (pend_q || sync_i) begin
        kind = SLOT_MARK;
      end else if (rem_q != '0) begin
        cell_ready_o = 1'b1;
        if (cell_valid_i) begin
          kind      = SLOT_DATA;
          scr_adv_o = 1'b1;
          rem_d     = rem_q - 1'b1;
        end
      end else if (cell_valid_i && cell_sof_i) begin
        rem_d = REM_W'(CELL_BYTES);
        if (cell_scr_rst_i) begin
          kind       = SLOT_CMD_RST;
          scr_load_o = 1'b1;
        end else begin
          kind = SLOT_CMD_KEEP;
        end
      end
    end
    pend_d = (kind == SLOT_MARK) ? 1'b0 : (pend_q || sync_i);
  end

  always_comb begin
    scr_byte = cell_data_i ^ key_i;
    case (kind)
      SLOT_DATA:     word_o = {enc_nib(scr_byte[7:4]), enc_nib(scr_byte[3:0])};
      SLOT_CMD_RST:  word_o = {SYM_ESC, SYM_ESC};
      SLOT_CMD_KEEP: word_o = {SYM_ESC, enc_nib(4'h4)};
      SLOT_MARK:     word_o = {SYM_ESC, enc_nib(4'h8)};
      default:       word_o = IDLE_WORD;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      rem_q  <= rem_d;
      pend_q <= pend_d;
    end
  end

  // R4: a held request is served at the slot boundary
  p_mark_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_end_i && pend_q) |=> !pend_q);
  // R5: each accepted byte lowers the remaining count by one
  p_cell_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cell_ready_o && cell_valid_i) |=> (rem_q == $past(rem_q) - 1'b1));
  // R2: a start-of-cell command arms a full cell
  p_sof_arms_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_end_i && !pend_q && !sync_i && rem_q == '0 && cell_valid_i && cell_sof_i)
      |=> (rem_q == REM_W'(CELL_BYTES)));
  p_rem_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rem_q <= REM_W'(CELL_BYTES));
endmodule

// File: rtl/cellframe_ser.sv
module cellframe_ser
  import cellframe_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] word_i,
  output logic              slot_end_o,
  output logic              line_o
);
  localparam int CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [WORD_W-1:0] sh_q, sh_d;
  logic              line_q, line_d;

  assign slot_end_o = (cnt_q == LAST);
  assign line_o     = line_q;

  always_comb begin
    cnt_d  = slot_end_o ? '0 : cnt_q + 1'b1;
    sh_d   = slot_end_o ? word_i : {sh_q[WORD_W-2:0], 1'b0};
    line_d = line_q ^ sh_q[WORD_W-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      sh_q   <= IDLE_WORD;
      line_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      sh_q   <= sh_d;
      line_q <= line_d;
    end
  end

  // R8: the chosen word enters the shifter whole at the boundary
  p_word_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    slot_end_o |=> (sh_q == $past(word_i)));
  // R11: boundaries never fall on adjacent clocks
  p_slot_gap_r11: assert property (@(posedge clk) disable iff (!rst_n)
    slot_end_o |=> !slot_end_o);
endmodule

// File: rtl/cellframe_tx.sv
module cellframe_tx
  import cellframe_pkg::*;
#(
  parameter int          CELL_BYTES = 53,
  parameter int          LFSR_W     = 10,
  parameter logic [9:0]  LFSR_TAPS  = 10'h240,
  parameter logic [9:0]  LFSR_SEED  = 10'h3FF
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] cell_data_i,
  input  logic       cell_valid_i,
  input  logic       cell_sof_i,
  input  logic       cell_scr_rst_i,
  output logic       cell_ready_o,
  input  logic       sync_i,
  output logic       line_o
);
  logic              slot_end;
  logic              scr_load, scr_adv;
  logic [BYTE_W-1:0] key;
  logic [WORD_W-1:0] word;

  cellframe_scrambler #(
    .LFSR_W (LFSR_W),
    .TAPS   (LFSR_W'(LFSR_TAPS)),
    .SEED   (LFSR_W'(LFSR_SEED)),
    .KEY_W  (BYTE_W)
  ) u_scr (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (scr_load),
    .adv_i  (scr_adv),
    .key_o  (key)
  );

  cellframe_sched #(
    .CELL_BYTES (CELL_BYTES)
  ) u_sched (
    .clk            (clk),
    .rst_n          (rst_n),
    .slot_end_i     (slot_end),
    .cell_data_i    (cell_data_i),
    .cell_valid_i   (cell_valid_i),
    .cell_sof_i     (cell_sof_i),
    .cell_scr_rst_i (cell_scr_rst_i),
    .sync_i         (sync_i),
    .key_i          (key),
    .cell_ready_o   (cell_ready_o),
    .scr_load_o     (scr_load),
    .scr_adv_o      (scr_adv),
    .word_o         (word)
  );

  cellframe_ser u_ser (
    .clk        (clk),
    .rst_n      (rst_n),
    .word_i     (word),
    .slot_end_o (slot_end),
    .line_o     (line_o)
  );

  // R1: a fresh reset leaves the handshake closed
  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !cell_ready_o);
endmodule

// File: tb/sim_cellframe_tx.sv
`timescale 1ns/1ps
module sim_cellframe_tx;
  localparam int NB = 53;
  localparam int NCASE = 6;
  localparam logic [9:0] TAPS = 10'h240;
  localparam logic [9:0] SEED = 10'h3FF;
  // {restart scrambler, sync at byte (255 none, 0 before command), data base}
  localparam logic [16:0] CASES [NCASE] = '{
    {1'b1, 8'd255, 8'h10},
    {1'b0, 8'd255, 8'h5A},
    {1'b0, 8'd20,  8'hC3},
    {1'b1, 8'd0,   8'h00},
    {1'b0, 8'd52,  8'hFF},
    {1'b1, 8'd30,  8'h77}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] cell_data = '0;
  logic cell_valid = 1'b0, cell_sof = 1'b0, cell_scr_rst = 1'b0, sync = 1'b0;
  logic cell_ready, line;

  always #10 clk = ~clk;

  cellframe_tx u0 (
    .clk(clk), .rst_n(rst_n), .cell_data_i(cell_data), .cell_valid_i(cell_valid),
    .cell_sof_i(cell_sof), .cell_scr_rst_i(cell_scr_rst), .cell_ready_o(cell_ready),
    .sync_i(sync), .line_o(line)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // ---------------- line decoder ----------------
  logic started;
  always @(posedge clk or negedge rst_n)
    if (!rst_n) started <= 1'b0; else started <= 1'b1;

  logic prev_line = 1'b0;
  logic [4:0] symsh = '0;
  int nbit = 0, phase = 0, first_sym = 0, pair_idx = 0;
  int cmd_count = 0, in_cell = 0, nbytes = 0;
  int bad = 0, idle_bad = 0, idle_pairs = 0, first_pair_idle = -1;
  int n_mk = 0;
  int mk_cell [16];
  int mk_pos  [16];
  int mk_pair [16];
  int cell_cmd [8];
  int rx  [8*NB];
  int exp_b [8*NB];
  logic [9:0] blfsr = SEED;

  function automatic int dec5(input logic [4:0] s);
    case (s)
      5'b11110: return 0;  5'b01001: return 1;  5'b10100: return 2;  5'b10101: return 3;
      5'b01010: return 4;  5'b01011: return 5;  5'b01110: return 6;  5'b01111: return 7;
      5'b10010: return 8;  5'b10011: return 9;  5'b10110: return 10; 5'b10111: return 11;
      5'b11010: return 12; 5'b11011: return 13; 5'b11100: return 14; 5'b11101: return 15;
      5'b11000: return 16;
      default:  return -1;
    endcase
  endfunction

  function automatic logic [7:0] next_key();
    logic [7:0] k;
    logic fb;
    for (int i = 0; i < 8; i++) begin
      fb = ^(blfsr & TAPS);
      k[7-i] = fb;
      blfsr = {blfsr[8:0], fb};
    end
    return k;
  endfunction

  task automatic take_pair(input int f, input int s);
    logic [7:0] b;
    if (first_pair_idle < 0) first_pair_idle = (f == 0 && s == 0) ? 1 : 0;
    if (f == 16) begin
      if (s == 16 || s == 4) begin
        cell_cmd[cmd_count] = (s == 16) ? 1 : 0;
        if (s == 16) blfsr = SEED;
        cmd_count++;
        in_cell = 1;
        nbytes = 0;
      end else if (s == 8) begin
        mk_cell[n_mk] = in_cell ? cmd_count - 1 : cmd_count;
        mk_pos[n_mk]  = in_cell ? nbytes : -1;
        mk_pair[n_mk] = pair_idx;
        n_mk++;
      end else bad++;
    end else if (f < 0 || s < 0 || s == 16) begin
      bad++;
    end else if (in_cell) begin
      b = {f[3:0], s[3:0]} ^ next_key();
      rx[(cmd_count-1)*NB + nbytes] = int'(b);
      nbytes++;
      if (nbytes == NB) in_cell = 0;
    end else begin
      idle_pairs++;
      if (f != 0 || s != 0) idle_bad++;
    end
  endtask

  always @(negedge clk) begin
    if (started) begin
      symsh = {symsh[3:0], line ^ prev_line};
      prev_line = line;
      nbit++;
      if (nbit == 5) begin
        nbit = 0;
        if (phase == 0) begin
          first_sym = dec5(symsh);
          phase = 1;
        end else begin
          phase = 0;
          take_pair(first_sym, dec5(symsh));
          pair_idx++;
        end
      end
    end
  end

  // ---------------- driver ----------------
  int gap_min = 1000, gap_max = 0, gap_sync = 0;

  task automatic send_cell(input int c, input bit rs, input int s, input logic [7:0] base);
    realtime t_prev;
    t_prev = 0;
    for (int i = 0; i < NB; i++) begin
      @(negedge clk);
      cell_data    = base + 8'(i * 7);
      exp_b[c*NB + i] = int'(8'(base + 8'(i * 7)));
      cell_valid   = 1'b1;
      cell_sof     = (i == 0);
      cell_scr_rst = rs;
      if (s == i) begin
        sync = 1'b1;
        @(negedge clk);
        sync = 1'b0;
      end
      #1;
      while (!cell_ready) begin
        @(negedge clk);
        #1;
      end
      if (i > 0) begin
        if (c == 1) begin
          if (int'(($realtime - t_prev) / 20.0) < gap_min) gap_min = int'(($realtime - t_prev) / 20.0);
          if (int'(($realtime - t_prev) / 20.0) > gap_max) gap_max = int'(($realtime - t_prev) / 20.0);
        end
        if (s == i) gap_sync = int'(($realtime - t_prev) / 20.0);
      end
      t_prev = $realtime;
      @(posedge clk);
    end
    @(negedge clk);
    cell_valid = 1'b0;
    cell_sof   = 1'b0;
  endtask

  task automatic check_cell(input int c, input bit rs, input int s, input bit chk_mk);
    int mis, cnt, pos;
    mis = 0;
    for (int i = 0; i < NB; i++) if (rx[c*NB+i] != exp_b[c*NB+i]) mis++;
    chk(cell_cmd[c] == int'(rs), rs ? "R2" : "R3", $sformatf("cell %0d command kind", c), cell_cmd[c], int'(rs));
    chk(mis == 0, "R7 R8 R9", $sformatf("cell %0d byte mismatches", c), mis, 0);
    if (chk_mk) begin
      cnt = 0; pos = -2;
      for (int m = 0; m < n_mk; m++) if (mk_cell[m] == c) begin cnt++; pos = mk_pos[m]; end
      if (s == 255) chk(cnt == 0, "R4", $sformatf("cell %0d marker count", c), cnt, 0);
      else begin
        chk(cnt == 1, "R4", $sformatf("cell %0d marker count", c), cnt, 1);
        chk(pos == ((s == 0) ? -1 : s), (s == 0) ? "R4" : "R5",
            $sformatf("cell %0d marker position", c), pos, (s == 0) ? -1 : s);
      end
    end
  endtask

  initial begin
    int m0;
    for (int i = 0; i < 8; i++) cell_cmd[i] = -1;
    repeat (3) @(negedge clk);
    chk(line == 1'b0, "R1", "line in reset", int'(line), 0);
    chk(cell_ready == 1'b0, "R1", "ready in reset", int'(cell_ready), 0);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(cell_ready == 1'b0, "R1", "ready after reset", int'(cell_ready), 0);
    repeat (40) @(negedge clk);
    chk(first_pair_idle == 1, "R1", "first slot is idle", first_pair_idle, 1);
    chk(idle_pairs >= 3 && idle_bad == 0, "R10", "idle bytes before traffic", idle_bad, 0);

    // table walk: back-to-back cells
    for (int c = 0; c < NCASE; c++)
      send_cell(c, CASES[c][16], int'(CASES[c][15:8]), CASES[c][7:0]);
    repeat (40) @(negedge clk);
    for (int c = 0; c < NCASE; c++)
      check_cell(c, CASES[c][16], int'(CASES[c][15:8]), 1'b1);
    chk(n_mk == 4, "R4", "markers after table", n_mk, 4);
    chk(gap_min == 10 && gap_max == 10, "R11", "byte spacing in plain cell", gap_max, 10);
    chk(gap_sync == 20, "R5", "spacing across inserted marker", gap_sync, 20);

    // two sync pulses, the second while the first marker is on the line
    m0 = n_mk;
    @(negedge clk); sync = 1'b1;
    @(negedge clk); sync = 1'b0;
    repeat (9) @(negedge clk);
    sync = 1'b1;
    @(negedge clk); sync = 1'b0;
    repeat (40) @(negedge clk);
    chk(n_mk == m0 + 2, "R6", "markers from two pulses", n_mk - m0, 2);
    chk(mk_pair[m0+1] == mk_pair[m0] + 1, "R6", "second marker slot offset", mk_pair[m0+1] - mk_pair[m0], 1);

    // a cell without restart after idle and markers: scrambler must have held
    send_cell(6, 1'b0, 255, 8'h3C);
    repeat (40) @(negedge clk);
    check_cell(6, 1'b0, 255, 1'b0);
    chk(bad == 0, "R8", "unknown symbol codes", bad, 0);
    chk(idle_bad == 0, "R10", "non-zero idle bytes", idle_bad, 0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule